// File: doc/BRIEF.md
# Row-Column Matrix Static RAM

This block is a synchronous behavioural model of an 8192-byte static RAM. The cells are held as a square matrix of 256 rows by 256 bit-columns. The 13-bit address is split in two. The upper part goes to a row decoder that picks exactly one row. The lower part goes to a location decoder that picks one of the 32 bytes packed into that row.

Access is allowed only while both chip enables are asserted. One enable is active low and the other is active high, so several devices can share one address bus and outside decode logic can pick one of them. The write strobe and the read strobe are both active low. The write strobe stores the input byte at the addressed location on the clock edge. The read strobe returns the stored byte one clock later, on a separate output port, and raises a valid flag with it. When no read is being served, the output reads zero and the flag is low.

Both one-hot decoder outputs are brought out as observation ports, so the address split can be checked from outside.

Top module: `sram_rc_matrix`

## Requirements
- R1: `row_sel_o` has exactly one bit set in every cycle, and that bit is at the index given by `addr_i[12:5]`.
- R2: `col_sel_o` has exactly one bit set in every cycle, and that bit is at the index given by `addr_i[4:0]`.
- R3: When `ce1_n_i`=0, `ce2_i`=1 and `wr_n_i`=0 at a rising clock edge, `din_i` is stored at `addr_i` on that edge.
- R4: When `ce1_n_i`=0, `ce2_i`=1, `rd_n_i`=0 and `wr_n_i`=1 at a rising edge, then after that edge `dout_o` holds the byte stored at `addr_i` and `dvalid_o`=1. This includes a byte written on the edge just before.
- R5: A write strobe given while `ce1_n_i`=1 or `ce2_i`=0 leaves the memory contents unchanged.
- R6: After any edge at which no read is taken (the device is deselected, or `rd_n_i`=1), `dvalid_o`=0 and `dout_o`=0.
- R7: When both strobes are low on a selected device, the write is performed, and after that edge `dvalid_o`=0 and `dout_o`=0.
- R8: While `rst_n` is low, `dvalid_o`=0 and `dout_o`=0. Memory cells are not cleared by reset.
- R9: A write changes only the addressed byte. Other bytes in the same row, and the byte at the same location in other rows, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the read output only |
| addr_i | input | 13 | Byte address: row index in [12:5], location index in [4:0] |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data; zero when no read is served |
| dvalid_o | output | 1 | High when `dout_o` carries read data |
| row_sel_o | output | 256 | One-hot row select from the row decoder |
| col_sel_o | output | 32 | One-hot location select from the column decoder |

## Verification
The two decoder outputs are combinational. They are checked 1 ns after each new address is driven, in the same cycle. A write takes effect on the edge that samples it, and `dout_o`/`dvalid_o` change on the edge that samples a read, so both output results are due exactly one edge after their stimulus. The driver applies one access per cycle on the falling edge and queues the expected `dvalid_o`/`dout_o` pair for that access. The monitor takes one queued item 1 ns after each rising edge and compares it there, so a read placed right after a write to the same address checks write-through on the next edge.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;

   // Default geometry
   localparam int unsigned DEF_ADDR_W = 13;
   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_ROW_W  = 8;

   // Kind of access taken at a clock edge
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_READ  = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/sram_onehot_dec.sv
module sram_onehot_dec #(
   parameter int unsigned IN_W = 5,
   localparam int unsigned OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  idx_i,
   output logic [OUT_N-1:0] sel_o
);

   if (IN_W < 1 || IN_W > 12) begin : g_bad_width
      $error("sram_onehot_dec: IN_W out of supported range");
   end

   for (genvar i = 0; i < OUT_N; i++) begin : g_out
      assign sel_o[i] = (idx_i == IN_W'(i));
   end

endmodule

// File: rtl/sram_cell_matrix.sv
module sram_cell_matrix #(
   parameter int unsigned ROWS   = 256,
   parameter int unsigned LOCS   = 32,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned ROW_BITS = LOCS * DATA_W
) (
   input  logic              clk,
   input  logic [ROWS-1:0]   row_sel_i,
   input  logic [LOCS-1:0]   col_sel_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [ROW_BITS-1:0] row_vec [ROWS];
   logic [ROW_BITS-1:0] row_word;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [ROW_BITS-1:0] cells_q;

      always_ff @(posedge clk) begin
         if (we_i && row_sel_i[r]) begin
            for (int c = 0; c < LOCS; c++) begin
               if (col_sel_i[c]) begin
                  cells_q[c*DATA_W +: DATA_W] <= wdata_i;
               end
            end
         end
      end

      assign row_vec[r] = cells_q;
   end

   // The one-hot row select gates each row onto the shared bit lines
   always_comb begin
      row_word = '0;
      for (int r = 0; r < ROWS; r++) begin
         row_word = row_word | (row_vec[r] & {ROW_BITS{row_sel_i[r]}});
      end
   end

   // The one-hot column select picks one byte out of the row
   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < LOCS; c++) begin
         rdata_o = rdata_o | (row_word[c*DATA_W +: DATA_W] & {DATA_W{col_sel_i[c]}});
      end
   end

endmodule

// File: rtl/sram_rc_matrix.sv
module sram_rc_matrix
   import sram_rc_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned ROW_W  = DEF_ROW_W,
   parameter bit          SQUARE = 1'b1,
   localparam int unsigned COL_W    = ADDR_W - ROW_W,
   localparam int unsigned ROWS     = 1 << ROW_W,
   localparam int unsigned LOCS     = 1 << COL_W,
   localparam int unsigned ROW_BITS = LOCS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce1_n_i,
   input  logic              ce2_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dvalid_o,
   output logic [ROWS-1:0]   row_sel_o,
   output logic [LOCS-1:0]   col_sel_o
);

   if (ROW_W < 1 || ROW_W >= ADDR_W) begin : g_bad_split
      $error("sram_rc_matrix: ROW_W must leave at least one column bit");
   end
   if (SQUARE && (ROW_BITS != ROWS)) begin : g_not_square
      $error("sram_rc_matrix: matrix is not square for these widths");
   end

   logic [ROW_W-1:0] row_idx;
   logic [COL_W-1:0] col_idx;
   logic             chip_sel;
   acc_kind_e        acc_kind;
   logic [DATA_W-1:0] cell_byte;
   logic [DATA_W-1:0] dout_q;
   logic              dvalid_q;

   assign row_idx  = addr_i[ADDR_W-1 -: ROW_W];
   assign col_idx  = addr_i[COL_W-1:0];
   assign chip_sel = !ce1_n_i && ce2_i;

   // Write wins when both strobes are low
   always_comb begin
      acc_kind = ACC_IDLE;
      if (chip_sel) begin
         if (!wr_n_i)      acc_kind = ACC_WRITE;
         else if (!rd_n_i) acc_kind = ACC_READ;
      end
   end

   sram_onehot_dec #(.IN_W(ROW_W)) u_row_dec (
      .idx_i (row_idx),
      .sel_o (row_sel_o)
   );

   sram_onehot_dec #(.IN_W(COL_W)) u_col_dec (
      .idx_i (col_idx),
      .sel_o (col_sel_o)
   );

   sram_cell_matrix #(
      .ROWS   (ROWS),
      .LOCS   (LOCS),
      .DATA_W (DATA_W)
   ) u_cells (
      .clk       (clk),
      .row_sel_i (row_sel_o),
      .col_sel_i (col_sel_o),
      .we_i      (acc_kind == ACC_WRITE),
      .wdata_i   (din_i),
      .rdata_o   (cell_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dvalid_q <= 1'b0;
      end else if (acc_kind == ACC_READ) begin
         dout_q   <= cell_byte;
         dvalid_q <= 1'b1;
      end else begin
         dout_q   <= '0;
         dvalid_q <= 1'b0;
      end
   end

   assign dout_o   = dout_q;
   assign dvalid_o = dvalid_q;

endmodule

// File: rtl/sram_rc_matrix_chk.sv
module sram_rc_matrix_chk #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ROW_W  = 8,
   localparam int unsigned COL_W = ADDR_W - ROW_W,
   localparam int unsigned ROWS  = 1 << ROW_W,
   localparam int unsigned LOCS  = 1 << COL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              ce1_n_i,
   input logic              ce2_i,
   input logic              wr_n_i,
   input logic              rd_n_i,
   input logic [DATA_W-1:0] din_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              dvalid_o,
   input logic [ROWS-1:0]   row_sel_o,
   input logic [LOCS-1:0]   col_sel_o
);

   logic sel_c, rd_take, wr_take;
   assign sel_c   = !ce1_n_i && ce2_i;
   assign rd_take = sel_c && !rd_n_i && wr_n_i;
   assign wr_take = sel_c && !wr_n_i;

   // R1
   a_r1_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(row_sel_o) == 1) && row_sel_o[addr_i[ADDR_W-1 -: ROW_W]]);

   // R2
   a_r2_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(col_sel_o) == 1) && col_sel_o[addr_i[COL_W-1:0]]);

   // R3 and R4: a write followed by a read of the same address returns the written byte
   a_r3_write_through: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take ##1 (rd_take && addr_i == $past(addr_i)) |=> (dvalid_o && dout_o == $past(din_i, 2)));

   // R4
   a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> dvalid_o);

   // R6
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_take |=> (!dvalid_o && dout_o == '0));

   // R7
   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_c && !wr_n_i && !rd_n_i) |=> !dvalid_o);

   // R8
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r8_reset_quiet: assert (!dvalid_o && dout_o == '0);
      end
   end

endmodule

bind sram_rc_matrix sram_rc_matrix_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .ROW_W  (ROW_W)
) chk_i (.*);

// File: tb/sram_rc_matrix_tb_top.sv
`timescale 1ns/1ps
module sram_rc_matrix_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] addr_i = '0;
   logic        ce1_n_i = 1'b1;
   logic        ce2_i = 1'b0;
   logic        wr_n_i = 1'b1;
   logic        rd_n_i = 1'b1;
   logic [7:0]  din_i = '0;
   logic [7:0]  dout_o;
   logic        dvalid_o;
   logic [255:0] row_sel_o;
   logic [31:0]  col_sel_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] model [int];
   string      tag_q [$];
   bit         v_q   [$];
   logic [7:0] d_q   [$];

   always #2.5 clk = ~clk;

   sram_rc_matrix dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .ce1_n_i   (ce1_n_i),
      .ce2_i     (ce2_i),
      .wr_n_i    (wr_n_i),
      .rd_n_i    (rd_n_i),
      .din_i     (din_i),
      .dout_o    (dout_o),
      .dvalid_o  (dvalid_o),
      .row_sel_o (row_sel_o),
      .col_sel_o (col_sel_o)
   );

   task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one access per cycle, applied on the falling edge
   task automatic drive(input bit c1n, input bit c2, input bit wn, input bit rn,
                        input logic [12:0] a, input logic [7:0] d, input string tag);
      bit sel, rd;
      @(negedge clk);
      ce1_n_i = c1n; ce2_i = c2; wr_n_i = wn; rd_n_i = rn; addr_i = a; din_i = d;
      sel = !c1n && c2;
      rd  = sel && !rn && wn;
      tag_q.push_back(tag);
      v_q.push_back(rd);
      d_q.push_back(rd ? model[int'(a)] : 8'h00);
      if (sel && !wn) model[int'(a)] = d;
      #1;
      check("R1 row select", row_sel_o, 256'(1) << a[12:5]);
      check("R2 column select", col_sel_o, 256'(32'(1) << a[4:0]));
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
      drive(1'b0, 1'b1, 1'b0, 1'b1, a, d, tag);
   endtask

   task automatic rd(input logic [12:0] a, input string tag);
      drive(1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00, tag);
   endtask

   // Monitor: compare one expected item after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (tag_q.size() > 0) begin
            string t;
            bit ev;
            logic [7:0] ed;
            t  = tag_q.pop_front();
            ev = v_q.pop_front();
            ed = d_q.pop_front();
            check({t, " valid"}, 256'(dvalid_o), 256'(ev));
            check({t, " data"}, 256'(dout_o), 256'(ed));
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset valid", 256'(dvalid_o), 256'(0));
      check("R8 reset data", 256'(dout_o), 256'(0));
      rst_n = 1'b1;

      // R3 R4 corner addresses, with a read right after each write
      wr(13'h0000, 8'h5A, "R3 write low");
      rd(13'h0000, "R4 read low");
      wr(13'h1FFF, 8'hA5, "R3 write high");
      rd(13'h1FFF, "R4 read high");

      // R9 neighbours in the same row and in the same column
      wr(13'h0123, 8'h11, "R9 write");
      wr(13'h0124, 8'h22, "R9 write");
      wr(13'h0143, 8'h33, "R9 write");
      wr(13'h0103, 8'h44, "R9 write");
      rd(13'h0123, "R9 same row a");
      rd(13'h0124, "R9 same row b");
      rd(13'h0143, "R9 same column next row");
      rd(13'h0103, "R9 same column prev row");

      // R5 deselected writes
      drive(1'b1, 1'b1, 1'b0, 1'b1, 13'h0123, 8'hFF, "R5 write ce1 high");
      drive(1'b0, 1'b0, 1'b0, 1'b1, 13'h0124, 8'hEE, "R5 write ce2 low");
      rd(13'h0123, "R5 unchanged a");
      rd(13'h0124, "R5 unchanged b");

      // R6 no read served
      drive(1'b1, 1'b1, 1'b1, 1'b0, 13'h0123, 8'h00, "R6 read ce1 high");
      drive(1'b0, 1'b0, 1'b1, 1'b0, 13'h0123, 8'h00, "R6 read ce2 low");
      drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0123, 8'h00, "R6 selected idle");
      rd(13'h0000, "R4 read again");
      drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0000, 8'h00, "R6 valid drops");

      // R7 both strobes low
      drive(1'b0, 1'b1, 1'b0, 1'b0, 13'h0124, 8'h77, "R7 both strobes");
      rd(13'h0124, "R7 write landed");

      // R3 R4 R9 spread of addresses
      for (int i = 0; i < 48; i++) begin
         wr(13'((i * 1237 + 91) % 8192), 8'((i * 29 + 3) % 256), "R3 sweep write");
      end
      for (int i = 0; i < 48; i++) begin
         rd(13'((i * 1237 + 91) % 8192), "R4 sweep read");
      end
      rd(13'h0143, "R9 after sweep");

      drive(1'b1, 1'b0, 1'b1, 1'b1, 13'h0000, 8'h00, "R6 final idle");
      repeat (3) @(negedge clk);
      check("scoreboard drained", 256'(tag_q.size()), 256'(0));
      finish_run();
   end

endmodule